// File: doc/BRIEF.md
# Scaled 64-bit System Counter

This block keeps a 64-bit physical time count that moves forward only on single-cycle tick pulses. When scaling is off, a qualified tick adds one to the count. When scaling is on, a qualified tick adds an unsigned 8.24 fixed-point increment. A hidden 24-bit fractional accumulator sits below the visible count and collects the fractional parts until they carry into the integer count. Two increment registers are held, one for each of two clock sources. A two-bit select input decides which register applies.

Software controls the block through an enable, a scaling switch, a halt-on-debug switch and a write port for the increment registers. It can also load any 64-bit value into the count. A debug-request input stops the count while halt-on-debug is set, and the block then reports that it is halted. The tick source, clock muxing and any register bus sit outside the block.

Top module: `scaled_sys_counter`

## Requirements
- R1: After reset the count is 0, the fractional accumulator is 0 and halted is 0. Both increment registers reset to 1.0, which is 32'h0100_0000.
- R2: With scaling off and the advance conditions met (tick high, enable high, not halted, valid select, no load), the count increases by exactly 1 at the next clock edge. A cycle with tick low leaves the count unchanged.
- R3: With scaling on, each qualified tick adds the active increment to the 88-bit value {count, fraction}. The increment has an 8-bit integer part in bits [31:24] and a 24-bit fraction in bits [23:0]. A carry out of the fraction advances the count.
- R4: A write with scaleWrEn high stores scaleWrData into increment register scaleWrSel (0 or 1) at the clock edge. Select code 2'b01 applies register 0 and code 2'b10 applies register 1.
- R5: Select codes 2'b00 and 2'b11 are invalid. A tick under an invalid code changes neither the count nor the fraction, whether scaling is on or off.
- R6: While cntEnable is low, ticks leave the count unchanged.
- R7: halted is 1 exactly while haltOnDbgEn and dbgReq are both 1, and during that time ticks leave the count unchanged. With haltOnDbgEn at 0, dbgReq has no effect.
- R8: A cycle with loadEn high sets the count to loadValue at the next edge and clears the fraction. The load takes priority over a tick in the same cycle.
- R9: The count wraps modulo 2^64 with no flag: all-ones plus 1 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Single-cycle counter tick |
| cntEnable | input | 1 | Count enable |
| scaleEnable | input | 1 | 1: add the scaled increment, 0: add 1 |
| haltOnDbgEn | input | 1 | Allow a debug request to halt the count |
| dbgReq | input | 1 | Debug request |
| clkSel | input | 2 | Clock-source select: 1 = source 0, 2 = source 1, 0 and 3 invalid |
| scaleWrEn | input | 1 | Write strobe for an increment register |
| scaleWrSel | input | 1 | Index of the increment register to write |
| scaleWrData | input | 32 | 8.24 increment value to write |
| loadEn | input | 1 | Load strobe for the count |
| loadValue | input | 64 | Value to load into the count |
| count | output | 64 | Current integer count |
| halted | output | 1 | 1 while the count is halted for debug |

## Verification
The fractional accumulator cannot be seen at the ports, so a wrong fraction shows up only as an integer carry that comes early or late. The vectors therefore use increments of 1.5, 0.25 and just under 256, and run each one long enough that a carry must or must not have happened by the time of the check. A fraction that a load fails to clear shows up as a count one too high, one tick after the load. Errors in the hold conditions (disable, halt, invalid select) and in load priority change the count at the very next edge, and the count is compared there.

// File: rtl/sysctr_pkg.sv
package sysctr_pkg;
  localparam int NUM_SRC = 2;

  typedef enum logic [1:0] {
    SEL_BAD_LO = 2'd0,
    SEL_SRC0   = 2'd1,
    SEL_SRC1   = 2'd2,
    SEL_BAD_HI = 2'd3
  } clk_sel_e;

  // Strobes from the control path to the datapath
  typedef struct packed {
    logic load;
    logic advance;
    logic useScale;
    logic srcIdx;
  } ctr_strobe_t;
endpackage

// File: rtl/sysctr_ctrl.sv
module sysctr_ctrl
  import sysctr_pkg::*;
(
  input  logic        tick,
  input  logic        cntEnable,
  input  logic        scaleEnable,
  input  logic        haltOnDbgEn,
  input  logic        dbgReq,
  input  logic [1:0]  clkSel,
  input  logic        loadEn,
  output ctr_strobe_t strobe,
  output logic        halted
);
  logic selValid;
  logic haltNow;

  always_comb begin
    selValid = (clk_sel_e'(clkSel) == SEL_SRC0) || (clk_sel_e'(clkSel) == SEL_SRC1);
    haltNow  = haltOnDbgEn && dbgReq;
    strobe.load     = loadEn;
    // a load wins over any increment in the same cycle
    strobe.advance  = !loadEn && tick && cntEnable && !haltNow && selValid;
    strobe.useScale = scaleEnable;
    strobe.srcIdx   = (clk_sel_e'(clkSel) == SEL_SRC1);
  end

  assign halted = haltNow;
endmodule

// File: rtl/sysctr_datapath.sv
module sysctr_datapath
  import sysctr_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int INT_W  = 8,
  parameter int FRAC_W = 24
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctr_strobe_t               strobe,
  input  logic                      scaleWrEn,
  input  logic                      scaleWrSel,
  input  logic [INT_W+FRAC_W-1:0]   scaleWrData,
  input  logic [CNT_W-1:0]          loadValue,
  output logic [CNT_W-1:0]          count
);
  localparam int SCALE_W = INT_W + FRAC_W;
  localparam int ACC_W   = CNT_W + FRAC_W;
  localparam logic [SCALE_W-1:0] SCALE_ONE = SCALE_W'(1) << FRAC_W;

  logic [SCALE_W-1:0] scaleReg [NUM_SRC];
  logic [FRAC_W-1:0]  fracAcc;
  logic [SCALE_W-1:0] activeScale;
  logic [ACC_W-1:0]   incr;
  logic [ACC_W-1:0]   accSum;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_scale
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        scaleReg[g] <= SCALE_ONE;
      end else if (scaleWrEn && (int'(scaleWrSel) == g)) begin
        scaleReg[g] <= scaleWrData;
      end
    end
  end

  always_comb begin
    activeScale = scaleReg[strobe.srcIdx];
    incr   = strobe.useScale ? ACC_W'(activeScale) : ACC_W'(SCALE_ONE);
    accSum = {count, fracAcc} + incr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      fracAcc <= '0;
    end else if (strobe.load) begin
      count   <= loadValue;
      fracAcc <= '0;
    end else if (strobe.advance) begin
      count   <= accSum[ACC_W-1:FRAC_W];
      fracAcc <= accSum[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/scaled_sys_counter.sv
module scaled_sys_counter
  import sysctr_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int INT_W  = 8,
  parameter int FRAC_W = 24
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    tick,
  input  logic                    cntEnable,
  input  logic                    scaleEnable,
  input  logic                    haltOnDbgEn,
  input  logic                    dbgReq,
  input  logic [1:0]              clkSel,
  input  logic                    scaleWrEn,
  input  logic                    scaleWrSel,
  input  logic [INT_W+FRAC_W-1:0] scaleWrData,
  input  logic                    loadEn,
  input  logic [CNT_W-1:0]        loadValue,
  output logic [CNT_W-1:0]        count,
  output logic                    halted
);
  ctr_strobe_t strobe;

  sysctr_ctrl u_ctrl (
    .tick        (tick),
    .cntEnable   (cntEnable),
    .scaleEnable (scaleEnable),
    .haltOnDbgEn (haltOnDbgEn),
    .dbgReq      (dbgReq),
    .clkSel      (clkSel),
    .loadEn      (loadEn),
    .strobe      (strobe),
    .halted      (halted)
  );

  sysctr_datapath #(
    .CNT_W  (CNT_W),
    .INT_W  (INT_W),
    .FRAC_W (FRAC_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .scaleWrEn   (scaleWrEn),
    .scaleWrSel  (scaleWrSel),
    .scaleWrData (scaleWrData),
    .loadValue   (loadValue),
    .count       (count)
  );
endmodule

// File: rtl/scaled_sys_counter_chk.sv
module scaled_sys_counter_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rstN,
  input logic             tick,
  input logic             cntEnable,
  input logic             scaleEnable,
  input logic             haltOnDbgEn,
  input logic             dbgReq,
  input logic [1:0]       clkSel,
  input logic             loadEn,
  input logic [CNT_W-1:0] loadValue,
  input logic [CNT_W-1:0] count,
  input logic             halted
);
  logic selOk;
  assign selOk = (clkSel == 2'd1) || (clkSel == 2'd2);

  p_unscaled_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (tick && cntEnable && !halted && !scaleEnable && selOk && !loadEn)
      |=> count == $past(count) + CNT_W'(1));

  p_invalid_sel_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && !selOk) |=> $stable(count));

  p_disabled_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && !cntEnable) |=> $stable(count));

  p_halt_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && halted) |=> $stable(count));

  p_halt_needs_enable_r7: assert property (@(posedge clk) disable iff (!rstN)
    !haltOnDbgEn |-> !halted);

  p_load_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> count == $past(loadValue));

  p_no_tick_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && !tick) |=> $stable(count));
endmodule

bind scaled_sys_counter scaled_sys_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .tick        (tick),
  .cntEnable   (cntEnable),
  .scaleEnable (scaleEnable),
  .haltOnDbgEn (haltOnDbgEn),
  .dbgReq      (dbgReq),
  .clkSel      (clkSel),
  .loadEn      (loadEn),
  .loadValue   (loadValue),
  .count       (count),
  .halted      (halted)
);

// File: tb/scaled_sys_counter_tb.sv
module scaled_sys_counter_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        cntEnable = 1'b0;
  logic        scaleEnable = 1'b0;
  logic        haltOnDbgEn = 1'b0;
  logic        dbgReq = 1'b0;
  logic [1:0]  clkSel = 2'd1;
  logic        scaleWrEn = 1'b0;
  logic        scaleWrSel = 1'b0;
  logic [31:0] scaleWrData = '0;
  logic        loadEn = 1'b0;
  logic [63:0] loadValue = '0;
  logic [63:0] count;
  logic        halted;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  scaled_sys_counter u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .cntEnable(cntEnable),
    .scaleEnable(scaleEnable), .haltOnDbgEn(haltOnDbgEn), .dbgReq(dbgReq),
    .clkSel(clkSel), .scaleWrEn(scaleWrEn), .scaleWrSel(scaleWrSel),
    .scaleWrData(scaleWrData), .loadEn(loadEn), .loadValue(loadValue),
    .count(count), .halted(halted)
  );

  typedef struct packed {
    logic [1:0]  sel;
    logic        sc;
    logic [7:0]  n;
    logic [63:0] exp;
  } vec_t;

  // Increment register 0 = 1.5 (32'h0180_0000), register 1 = 0.25 (32'h0040_0000)
  localparam vec_t VECS [8] = '{
    '{sel: 2'd1, sc: 1'b0, n: 8'd5, exp: 64'd5}, // R2
    '{sel: 2'd1, sc: 1'b1, n: 8'd4, exp: 64'd6}, // R3 R4 1.5*4
    '{sel: 2'd1, sc: 1'b1, n: 8'd3, exp: 64'd4}, // R3 4.5 floors to 4
    '{sel: 2'd2, sc: 1'b1, n: 8'd3, exp: 64'd0}, // R3 R4 0.75
    '{sel: 2'd2, sc: 1'b1, n: 8'd4, exp: 64'd1}, // R3 carry at 1.0
    '{sel: 2'd2, sc: 1'b1, n: 8'd9, exp: 64'd2}, // R3 2.25
    '{sel: 2'd0, sc: 1'b1, n: 8'd5, exp: 64'd0}, // R5
    '{sel: 2'd3, sc: 1'b0, n: 8'd5, exp: 64'd0}  // R5
  };

  task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doLoad(logic [63:0] v);
    @(negedge clk);
    loadEn = 1'b1;
    loadValue = v;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic doTicks(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick = 1'b1;
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic writeScale(logic idx, logic [31:0] v);
    @(negedge clk);
    scaleWrEn = 1'b1;
    scaleWrSel = idx;
    scaleWrData = v;
    @(negedge clk);
    scaleWrEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check64("R1 count at reset", count, 64'd0);
    check64("R1 halted at reset", {63'd0, halted}, 64'd0);
    rstN = 1'b1;
    cntEnable = 1'b1;

    // R1: reset increment of 1.0 on source 0 behaves like +1
    scaleEnable = 1'b1;
    clkSel = 2'd1;
    doTicks(3);
    check64("R1 reset increment 1.0", count, 64'd3);

    writeScale(1'b0, 32'h0180_0000);
    writeScale(1'b1, 32'h0040_0000);

    for (int i = 0; i < 8; i++) begin
      clkSel = VECS[i].sel;
      scaleEnable = VECS[i].sc;
      doLoad(64'd0);
      doTicks(int'(VECS[i].n));
      check64($sformatf("R2/R3/R4/R5 vector %0d", i), count, VECS[i].exp);
    end

    // R6: disabled holds
    clkSel = 2'd1;
    scaleEnable = 1'b0;
    doLoad(64'd100);
    cntEnable = 1'b0;
    doTicks(4);
    check64("R6 disabled hold", count, 64'd100);
    cntEnable = 1'b1;

    // R7: halt with debug request
    haltOnDbgEn = 1'b1;
    dbgReq = 1'b1;
    @(negedge clk);
    check64("R7 halted flag", {63'd0, halted}, 64'd1);
    doTicks(4);
    check64("R7 halted hold", count, 64'd100);
    haltOnDbgEn = 1'b0;
    @(negedge clk);
    check64("R7 no halt without enable", {63'd0, halted}, 64'd0);
    doTicks(2);
    check64("R7 dbgReq ignored", count, 64'd102);
    dbgReq = 1'b0;

    // R8: load beats tick in the same cycle
    @(negedge clk);
    tick = 1'b1;
    loadEn = 1'b1;
    loadValue = 64'h1234_5678_9abc_def0;
    @(negedge clk);
    tick = 1'b0;
    loadEn = 1'b0;
    check64("R8 load priority", count, 64'h1234_5678_9abc_def0);

    // R8: load clears the fraction (0.75 left over, then load 10, one 0.25 tick)
    clkSel = 2'd2;
    scaleEnable = 1'b1;
    doLoad(64'd0);
    doTicks(3);
    doLoad(64'd10);
    doTicks(1);
    check64("R8 fraction cleared", count, 64'd10);

    // R3: near-256 increment, two ticks -> 511
    writeScale(1'b0, 32'hFFFF_FFFF);
    clkSel = 2'd1;
    doLoad(64'd0);
    doTicks(2);
    check64("R3 max increment carry", count, 64'd511);

    // R9: wrap
    scaleEnable = 1'b0;
    doLoad(64'hFFFF_FFFF_FFFF_FFFF);
    doTicks(1);
    check64("R9 wrap to zero", count, 64'd0);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule